// File: doc/BRIEF.md
# Page Command Sequencer with One-Deep Buffer

This block runs page-sized jobs for a speech recorder that keeps delta-modulated bits in a one-bit-wide DRAM. A page is 1024 bits. A job is a page transfer or a timed pause. A transfer stores encoded bits into a page when the mode selects encode, and reads a page back out when the mode selects decode. A pause lasts one page worth of bit periods. A single command slot holds the next job, so the controller can queue work ahead of time. A newer command replaces whatever is waiting in the slot. When the running job ends, the queued job starts on the very next bit period.

Bit periods come from a one-cycle `bit_tick` pulse, derived elsewhere from the sample rate. Each tick of a running transfer issues exactly one DRAM bit access, on address `{page, bit index}`. In decode mode the output stream carries the page data during playback. At every other tick it carries an alternating 1,0,1,0 idle pattern: during a pause, and when no job is running. A store made while the codec is powersaved writes that same pattern instead of the encoder bits.

Both streams are paced by the sample rate, so neither side can stall them. `enc_ready` is raised only on a tick of an active, non-powersaved store. A bit is taken when `enc_valid` and `enc_ready` are both high; if `enc_valid` is low at that tick, 0 is written. `out_valid` is a one-cycle strobe with no ready: the consumer must take every bit. Read data must return on `mem_rvalid` before the next tick.

Top module: `page_seq`

## Requirements
- R1: After reset `st_empty`=1, `st_idle`=1, `st_power`=0, and neither `mem_req` nor `out_valid` is asserted.
- R2: `st_empty` falls in the cycle after a command is accepted on `cmd_valid`. It rises again in the cycle after the slot's command enters execution, which happens one cycle after loading when nothing is running. `st_idle` falls at that same point.
- R3: A command accepted while the slot is already full replaces the waiting command, and only the newest one is executed.
- R4: A transfer issues exactly 1024 bit accesses, one per tick, with addresses `{page, index}` and index rising from 0 to 1023.
- R5: The direction of a transfer is taken from `mode_decode` when it starts: 0 gives writes (`mem_we`=1) of the accepted encoder bits, 1 gives reads (`mem_we`=0).
- R6: When a job ends with a command waiting, that command's index 0 access falls on the tick after the last tick of the previous job, and `st_idle` stays 0 throughout.
- R7: When a job ends with the slot empty, `st_idle` is 1 in the cycle after its last tick.
- R8: A pause (`cmd_wait`=1) lasts 1024 ticks and issues no DRAM access. In decode mode it emits 1,0,1,0,… starting with 1.
- R9: In decode mode with no job running, each tick emits one idle bit, alternating and starting with 1 after reset.
- R10: A store run with `mode_powersave`=1 writes 1 at even and 0 at odd indices, and never raises `enc_ready`.
- R11: At the end of a store, or of a pause in encode mode, `st_power` loads `power_in` clamped to 31. Playback and decode-mode pauses leave it unchanged.
- R12: The page of a job is `cmd_page`, and it forms address bits [21:10].
- R13: During playback each returned read bit is emitted on `out_bit` with `out_valid` one cycle after `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe: load a command into the slot |
| cmd_wait | input | 1 | 1 = pause job, 0 = page transfer |
| cmd_page | input | 12 | Page number of a transfer |
| mode_decode | input | 1 | 1 = play (decode), 0 = store (encode) |
| mode_powersave | input | 1 | Codec powersaved |
| bit_tick | input | 1 | One-cycle bit-period pulse |
| power_in | input | 8 | Raw input level from the encoder |
| enc_valid | input | 1 | Encoder bit available |
| enc_bit | input | 1 | Encoder bit |
| enc_ready | output | 1 | Encoder bit taken this cycle |
| mem_req | output | 1 | DRAM bit access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 22 | Bit address {page, index} |
| mem_wdata | output | 1 | Write bit |
| mem_rvalid | input | 1 | Read bit returned |
| mem_rdata | input | 1 | Read bit |
| out_valid | output | 1 | Output stream strobe |
| out_bit | output | 1 | Output stream bit |
| st_empty | output | 1 | Command slot empty |
| st_idle | output | 1 | No job running |
| st_power | output | 5 | Latched power reading |

## Verification
The bench queues two further commands behind a running store, the second replacing the first. A design that kept the older one writes the wrong page, and one that paused between jobs shows up as a four-cycle-plus gap or a raised idle flag at the seam. It plays a page back to check that the data and the read timing come through intact. It checks that pauses never touch DRAM and emit an alternating pattern that starts with 1. A powersaved store must write that pattern without pulling encoder bits; a design that mixed them up writes encoder data or raises `enc_ready`. The power reading is driven above 31 to catch a missing clamp, and changed during playback and a decode-mode pause to catch a latch that fires in the wrong mode.

// File: rtl/page_seq_pkg.sv
package page_seq_pkg;

  typedef enum logic [1:0] {
    K_STORE = 2'd0,
    K_PLAY  = 2'd1,
    K_WAIT  = 2'd2
  } job_kind_e;

  // clamp a raw level into the 5-bit reading
  function automatic logic [4:0] clamp_level(input logic [7:0] raw);
    return (raw > 8'd31) ? 5'd31 : raw[4:0];
  endfunction

endpackage

// File: rtl/page_seq_slot.sv
module page_seq_slot #(
  parameter int PAGE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_wait,
  input  logic [PAGE_W-1:0] load_page,
  input  logic              take,
  output logic              full,
  output logic              slot_wait,
  output logic [PAGE_W-1:0] slot_page
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      slot_wait <= 1'b0;
      slot_page <= '0;
    end else if (load) begin
      // newest command always wins, even over a simultaneous take
      full      <= 1'b1;
      slot_wait <= load_wait;
      slot_page <= load_page;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  a_r3_newest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (full && slot_page == $past(load_page) && slot_wait == $past(load_wait)));

  a_r2_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load) |=> !full);

endmodule

// File: rtl/page_seq_exec.sv
module page_seq_exec
  import page_seq_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              dir_decode,
  input  logic              slot_full,
  input  logic              slot_wait,
  input  logic [PAGE_W-1:0] slot_page,
  output logic              take,
  output logic              finish,
  output logic              active,
  output job_kind_e         kind,
  output logic [PAGE_W-1:0] page,
  output logic [CNT_W-1:0]  cnt
);

  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  assign finish = active && tick && (cnt == LAST);
  assign take   = slot_full && (!active || finish);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      kind   <= K_WAIT;
      page   <= '0;
      cnt    <= '0;
    end else if (take) begin
      active <= 1'b1;
      kind   <= slot_wait ? K_WAIT : (dir_decode ? K_PLAY : K_STORE);
      page   <= slot_page;
      cnt    <= '0;
    end else if (finish) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r4_one_step_per_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && !finish) |=> (active && cnt == $past(cnt) + 1'b1));

  a_r6_seamless_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && slot_full) |=> (active && cnt == '0));

endmodule

// File: rtl/page_seq_router.sv
module page_seq_router
  import page_seq_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int CNT_W  = 10,
  localparam int ADDR_W = PAGE_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              active,
  input  job_kind_e         kind,
  input  logic [PAGE_W-1:0] page,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              decode,
  input  logic              powersave,
  input  logic              enc_valid,
  input  logic              enc_bit,
  output logic              enc_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wdata,
  input  logic              mem_rvalid,
  input  logic              mem_rdata,
  output logic              out_valid,
  output logic              out_bit
);

  logic step, patt, emit, idle_ph, idle_bit;

  assign step      = active && tick;
  assign patt      = ~cnt[0];
  assign mem_req   = step && (kind != K_WAIT);
  assign mem_we    = (kind == K_STORE);
  assign mem_addr  = {page, cnt};
  assign enc_ready = step && (kind == K_STORE) && !powersave;
  assign mem_wdata = powersave ? patt : (enc_valid & enc_bit);

  // idle bit goes out on every decode tick that is not a playback access
  assign emit     = tick && decode && !(active && kind == K_PLAY);
  assign idle_bit = (active && kind == K_WAIT) ? patt : ~idle_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_ph   <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      if (emit && !active) idle_ph <= ~idle_ph;
      out_valid <= emit | mem_rvalid;
      out_bit   <= mem_rvalid ? mem_rdata : idle_bit;
    end
  end

  a_r13_read_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |=> (out_valid && out_bit == $past(mem_rdata)));

endmodule

// File: rtl/page_seq.sv
module page_seq
  import page_seq_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int CNT_W  = 10,
  parameter int LVL_W  = 8,
  localparam int ADDR_W = PAGE_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_wait,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic              mode_decode,
  input  logic              mode_powersave,
  input  logic              bit_tick,
  input  logic [LVL_W-1:0]  power_in,
  input  logic              enc_valid,
  input  logic              enc_bit,
  output logic              enc_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wdata,
  input  logic              mem_rvalid,
  input  logic              mem_rdata,
  output logic              out_valid,
  output logic              out_bit,
  output logic              st_empty,
  output logic              st_idle,
  output logic [4:0]        st_power
);

  logic              full, slot_wait, take, finish, active;
  logic [PAGE_W-1:0] slot_page, page;
  logic [CNT_W-1:0]  cnt;
  job_kind_e         kind;
  logic [7:0]        lvl8;

  page_seq_slot #(.PAGE_W(PAGE_W)) slot_i (
    .clk(clk), .rst_n(rst_n), .load(cmd_valid), .load_wait(cmd_wait),
    .load_page(cmd_page), .take(take), .full(full), .slot_wait(slot_wait),
    .slot_page(slot_page)
  );

  page_seq_exec #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) exec_i (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .dir_decode(mode_decode),
    .slot_full(full), .slot_wait(slot_wait), .slot_page(slot_page),
    .take(take), .finish(finish), .active(active), .kind(kind),
    .page(page), .cnt(cnt)
  );

  page_seq_router #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) router_i (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .active(active), .kind(kind),
    .page(page), .cnt(cnt), .decode(mode_decode), .powersave(mode_powersave),
    .enc_valid(enc_valid), .enc_bit(enc_bit), .enc_ready(enc_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  generate
    if (LVL_W >= 8) begin : g_lvl_wide
      assign lvl8 = (|power_in[LVL_W-1:0] && (power_in > LVL_W'(255))) ? 8'hFF : power_in[7:0];
    end else begin : g_lvl_narrow
      assign lvl8 = 8'(power_in);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_power <= '0;
    end else if (finish && (kind == K_STORE || (kind == K_WAIT && !mode_decode))) begin
      st_power <= clamp_level(lvl8);
    end
  end

  assign st_empty = !full;
  assign st_idle  = !active;

  a_r2_load_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !st_empty);

  a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !full) |=> st_idle);

  a_r11_power_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && kind == K_STORE) |=> (st_power <= 5'd31 && (st_power == $past(clamp_level(lvl8)))));

endmodule

// File: tb/page_seq_tb_top.sv
`timescale 1ns/1ps
module page_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_wait = 1'b0;
  logic [11:0] cmd_page = '0;
  logic mode_decode = 1'b1, mode_powersave = 1'b0, bit_tick = 1'b0;
  logic [7:0] power_in = '0;
  logic enc_valid = 1'b1, enc_bit;
  logic enc_ready, mem_req, mem_we, mem_wdata, out_valid, out_bit;
  logic [21:0] mem_addr;
  logic mem_rvalid = 1'b0, mem_rdata = 1'b0;
  logic st_empty, st_idle;
  logic [4:0] st_power;

  always #2 clk = ~clk;

  page_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wait(cmd_wait),
    .cmd_page(cmd_page), .mode_decode(mode_decode), .mode_powersave(mode_powersave),
    .bit_tick(bit_tick), .power_in(power_in), .enc_valid(enc_valid), .enc_bit(enc_bit),
    .enc_ready(enc_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_bit(out_bit), .st_empty(st_empty), .st_idle(st_idle),
    .st_power(st_power)
  );

  int n_tests = 0, n_fail = 0;
  int exp_out[$];
  int exp_wr[$];
  bit dram [int];
  int acc = 0, cyc = 0, div = 0;
  bit tick_en = 1'b0, out_chk = 1'b0, gap_watch = 1'b0;
  int wait_req_cnt = 0, ready_cnt = 0, gap_cnt = 0, wr_seen = 0;
  int last5_cyc = -1, first3_cyc = -1;

  function automatic bit fbit(input int k);
    return k[0] ^ k[3] ^ k[7];
  endfunction

  assign enc_bit = fbit(acc);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bit-period pulse: one cycle in four while enabled
  initial forever begin
    @(posedge clk); #1;
    div = (div + 1) % 4;
    bit_tick = tick_en && (div == 0);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (enc_valid && enc_ready) acc <= acc + 1;
    mem_rvalid <= 1'b0;
    if (mem_req && mem_we) dram[int'(mem_addr)] = mem_wdata;
    if (mem_req && !mem_we) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= dram.exists(int'(mem_addr)) ? dram[int'(mem_addr)] : 1'b0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    int e;
    if (rst_n) begin
      if (out_valid && out_chk) begin
        if (exp_out.size() == 0) check(1'b0, "R9/R13 unexpected out bit", 1, 0);
        else begin
          e = exp_out.pop_front();
          check(out_bit == e[0], "R8/R9/R13 out_bit", out_bit, e);
        end
      end
      if (mem_req && mem_we) begin
        wr_seen++;
        if (exp_wr.size() == 0) check(1'b0, "R4 unexpected write", int'(mem_addr), -1);
        else begin
          e = exp_wr.pop_front();
          check({mem_addr, mem_wdata} == 23'(e), "R4/R5/R10/R12 write addr+data",
                int'({mem_addr, mem_wdata}), e);
          if (mem_addr == {12'd5, 10'd1023}) last5_cyc = cyc;
          if (mem_addr == {12'd3, 10'd0}) first3_cyc = cyc;
        end
      end
      if (mem_req && dut_in_wait) wait_req_cnt++;
      if (enc_ready) ready_cnt++;
      if (gap_watch && exp_wr.size() > 0 && st_idle) gap_cnt++;
    end
  end

  bit dut_in_wait = 1'b0;

  task automatic send(input bit w, input logic [11:0] p);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_wait = w; cmd_page = p;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_busy();
    do @(negedge clk); while (st_idle);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!st_idle);
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(st_empty == 1'b1, "R1 st_empty", st_empty, 1);
    check(st_idle == 1'b1, "R1 st_idle", st_idle, 1);
    check(st_power == 5'd0, "R1 st_power", st_power, 0);
    check(mem_req == 1'b0 && out_valid == 1'b0, "R1 quiet outputs", mem_req | out_valid, 0);

    // R9 idle pattern in decode with nothing running
    out_chk = 1'b1;
    for (int k = 0; k < 8; k++) exp_out.push_back((k % 2 == 0) ? 1 : 0);
    tick_en = 1'b1;
    while (exp_out.size() > 0) @(negedge clk);
    tick_en = 1'b0;
    repeat (8) @(negedge clk);
    out_chk = 1'b0;
    check(exp_out.size() == 0, "R9 idle bits drained", exp_out.size(), 0);

    // store two pages back to back, with a replaced buffered command
    mode_decode = 1'b0; power_in = 8'd200; acc = 0;
    for (int k = 0; k < 1024; k++) exp_wr.push_back(((5 * 1024 + k) * 2) + fbit(k));
    for (int k = 0; k < 1024; k++) exp_wr.push_back(((3 * 1024 + k) * 2) + fbit(1024 + k));
    send(1'b0, 12'd5);
    @(negedge clk);
    check(st_empty == 1'b0, "R2 empty falls on load", st_empty, 0);
    check(st_idle == 1'b1, "R2 idle before start", st_idle, 1);
    @(negedge clk);
    check(st_empty == 1'b1, "R2 empty rises on start", st_empty, 1);
    check(st_idle == 1'b0, "R2 idle falls on start", st_idle, 0);
    tick_en = 1'b1; gap_watch = 1'b1;
    repeat (40) @(negedge clk);
    send(1'b0, 12'd9);
    @(negedge clk);
    check(st_empty == 1'b0, "R2 empty falls while busy", st_empty, 0);
    send(1'b0, 12'd3);   // R3: replaces page 9
    while (exp_wr.size() > 0) @(negedge clk);
    @(negedge clk);
    tick_en = 1'b0;
    check(st_idle == 1'b1, "R7 idle after last tick", st_idle, 1);
    check(st_empty == 1'b1, "R7 slot empty at end", st_empty, 1);
    check(gap_cnt == 0, "R6 no idle at seam", gap_cnt, 0);
    check(first3_cyc - last5_cyc == 4, "R6 next page on next tick", first3_cyc - last5_cyc, 4);
    check(wr_seen == 2048, "R4 exactly one page per job (R3 page 9 dropped)", wr_seen, 2048);
    check(ready_cnt == 2048, "R5 encoder bits accepted", ready_cnt, 2048);
    check(st_power == 5'd31, "R11 clamp to 31", st_power, 31);
    gap_watch = 1'b0;

    // play page 3 back
    power_in = 8'd4; mode_decode = 1'b1;
    for (int k = 0; k < 1024; k++) exp_out.push_back(fbit(1024 + k));
    send(1'b0, 12'd3);
    wait_busy();
    out_chk = 1'b1; tick_en = 1'b1;
    wait_idle();
    tick_en = 1'b0;
    repeat (6) @(negedge clk);
    out_chk = 1'b0;
    check(exp_out.size() == 0, "R13 all page bits played", exp_out.size(), 0);
    check(wr_seen == 2048, "R5 play issues no writes", wr_seen, 2048);
    check(st_power == 5'd31, "R11 play leaves power", st_power, 31);

    // decode-mode pause
    for (int k = 0; k < 1024; k++) exp_out.push_back((k % 2 == 0) ? 1 : 0);
    wait_req_cnt = 0;
    send(1'b1, 12'd0);
    wait_busy();
    dut_in_wait = 1'b1; out_chk = 1'b1; tick_en = 1'b1;
    wait_idle();
    tick_en = 1'b0;
    repeat (6) @(negedge clk);
    out_chk = 1'b0; dut_in_wait = 1'b0;
    check(exp_out.size() == 0, "R8 pause emitted 1024 pattern bits", exp_out.size(), 0);
    check(wait_req_cnt == 0, "R8 pause makes no DRAM access", wait_req_cnt, 0);
    check(st_power == 5'd31, "R11 decode pause leaves power", st_power, 31);

    // powersaved store
    mode_decode = 1'b0; mode_powersave = 1'b1; power_in = 8'd17; ready_cnt = 0;
    for (int k = 0; k < 1024; k++) exp_wr.push_back(((2 * 1024 + k) * 2) + ((k % 2 == 0) ? 1 : 0));
    send(1'b0, 12'd2);
    wait_busy();
    tick_en = 1'b1;
    wait_idle();
    tick_en = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_out.size() == 0 && exp_wr.size() == 0, "R10 pattern page written", exp_wr.size(), 0);
    check(ready_cnt == 0, "R10 encoder untouched", ready_cnt, 0);
    check(st_power == 5'd17, "R11 unclamped reading", st_power, 17);

    // encode-mode pause latches power
    mode_powersave = 1'b0; power_in = 8'd9;
    send(1'b1, 12'd0);
    wait_busy();
    tick_en = 1'b1;
    wait_idle();
    tick_en = 1'b0;
    @(negedge clk);
    check(st_power == 5'd9, "R11 encode pause latches", st_power, 9);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule